// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from one input clock. Software-side logic loads two configuration words while the block is disabled. The control word selects between standard and fast timing, picks the duty ratio for fast timing, and carries a 12-bit period count N. The rise word sets how many input clocks the released line may stay low before it counts as a rise-time fault. A byte-transfer engine asserts `run` to keep clocks flowing. It uses the one-cycle strobes `low_stb` and `high_stb` to move data and sample bits at the start of each phase.

SCL is open-drain. The block only asserts `scl_pull`, which drives the pad low, or releases the line. After each low phase the sequencer releases SCL and waits in a sensing state until `scl_in` reads high. Only then does it start timing the high phase. A slave can stretch the clock this way, and slow rise times do not shorten the high phase. If the line stays low after release for longer than the rise word, a sticky violation flag is set. The flag is not set while `stretch_hold` reports a deliberate stretch.

The sequencer has four states:
- IDLE: released, counters cleared.
- LOW: SCL pulled low for L clocks.
- RISE: released, waiting for the line to read high.
- HIGH: released for H clocks.

It has these transitions:
- IDLE→LOW when enabled and `run` is high.
- LOW→RISE when the L-th low clock ends.
- RISE→HIGH when `scl_in` is sampled high.
- HIGH→LOW at the end of the H-th high clock if `run` is high.
- HIGH→IDLE at the end of the H-th high clock if `run` is low.
- Any state→IDLE whenever `en` is low.

Top module: `scl_rate_gen`

## Requirements
- R1: Control word fields are bit 13 = fast, bit 12 = duty select, bits 11:0 = N. With fast = 0, each SCL period is N clocks with `scl_pull` high, then N clocks of HIGH state. The HIGH clocks are measured from the `high_stb` cycle to the next pull.
- R2: With fast = 1 and duty = 0, the low phase lasts 2N clocks and the HIGH state lasts N clocks.
- R3: With fast = 1 and duty = 1, the low phase lasts 16N clocks and the HIGH state lasts 9N clocks.
- R4: With fast = 0, the duty bit has no effect on either phase length.
- R5: N = 0 gives exactly the phase lengths of N = 1 in every mode.
- R6: `cfg_we` loads both configuration words only on an edge where `en` is low. Loads attempted while `en` is high leave the timing unchanged, including after a later disable and re-enable.
- R7: While `en` is low, and after reset, `scl_pull`, `low_stb`, `high_stb` and `rise_viol` are all low. Disabling takes effect at the next clock edge.
- R8: The first low phase, with `scl_pull` = 1 and `low_stb` = 1, begins in the cycle after the edge that samples `en` and `run` both high. `low_stb` is high only in the first clock of each low phase, and `high_stb` only in the first clock of each HIGH state.
- R9: After release, HIGH is entered one clock after `scl_in` is sampled high. While the line is held low, no `high_stb` occurs.
- R10: While released and waiting, count the edges at which `scl_in` = 0 and `stretch_hold` = 0. When that count exceeds the rise word R, `rise_viol` is set at the (R+1)-th such edge. It stays set until `en` is low.
- R11: If `run` is low at the end of a HIGH state, the generator returns to IDLE and keeps SCL released with no further strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Peripheral enable |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_ctrl | input | 14 | Control word: fast, duty, period count N |
| cfg_rise | input | 6 | Rise-time limit in clocks |
| run | input | 1 | Request continued clocking |
| scl_in | input | 1 | Sensed SCL line level |
| stretch_hold | input | 1 | A slave is stretching on purpose; suppresses the fault |
| scl_pull | output | 1 | 1 = drive SCL low, 0 = release |
| low_stb | output | 1 | First clock of a low phase |
| high_stb | output | 1 | First clock of a high phase |
| rise_viol | output | 1 | Sticky rise-time violation |

## Verification
Every output is decoded from registered state, so each result is due in the cycle after the edge that sampled its cause:
- a start request shows as `scl_pull` one clock later;
- a line seen high shows as `high_stb` one clock later;
- the fault flag rises one clock after the (R+1)-th low sampling edge.

The bench's behavioural model advances at the same rising edge as the design, and every output is compared on the falling edge. Inputs change only on falling edges. The targeted checks count falling edges from a known strobe, so they look exactly where each value is due.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Sequencer states of the SCL generator
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // released, nothing running
        ST_LOW  = 2'd1,   // SCL pulled low
        ST_RISE = 2'd2,   // released, waiting to sense the line high
        ST_HIGH = 2'd3    // released, timing the high phase
    } scl_state_e;

    localparam int DEF_CCR_W  = 12;
    localparam int DEF_RISE_W = 6;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
    parameter int CCR_W  = 12,
    parameter int RISE_W = 6,
    localparam int CTRL_W   = CCR_W + 2,
    localparam int FAST_POS = CTRL_W - 1,
    localparam int DUTY_POS = CTRL_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [RISE_W-1:0] cfg_rise,
    output logic              fast_q,
    output logic              duty_q,
    output logic [CCR_W-1:0]  count_q,
    output logic [RISE_W-1:0] rise_q
);

    logic load;
    assign load = cfg_we && !en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q  <= 1'b0;
            duty_q  <= 1'b0;
            count_q <= '0;
            rise_q  <= '1;
        end else if (load) begin
            fast_q  <= cfg_ctrl[FAST_POS];
            duty_q  <= cfg_ctrl[DUTY_POS];
            count_q <= cfg_ctrl[CCR_W-1:0];
            rise_q  <= cfg_rise;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($stable(fast_q) && $stable(duty_q) && $stable(count_q) && $stable(rise_q))); // R6

endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
    parameter int CCR_W = 12,
    parameter int LEN_W = 17
) (
    input  logic             fast,
    input  logic             duty,
    input  logic [CCR_W-1:0] count,
    output logic [LEN_W-1:0] lo_len,
    output logic [LEN_W-1:0] hi_len
);

    logic [LEN_W-1:0] base;

    // a zero count is promoted to one so no phase is ever empty
    assign base = (count == '0) ? LEN_W'(1) : LEN_W'(count);

    always_comb begin
        if (!fast) begin
            lo_len = base;
            hi_len = base;
        end else if (duty) begin
            lo_len = base << 4;
            hi_len = (base << 3) + base;
        end else begin
            lo_len = base << 1;
            hi_len = base;
        end
    end

endmodule

// File: rtl/scl_seq.sv
module scl_seq
    import scl_gen_pkg::*;
#(
    parameter int LEN_W  = 17,
    parameter int RISE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              run,
    input  logic              scl_in,
    input  logic              stretch_hold,
    input  logic [LEN_W-1:0]  lo_len,
    input  logic [LEN_W-1:0]  hi_len,
    input  logic [RISE_W-1:0] rise_lim,
    output logic              scl_pull,
    output logic              low_stb,
    output logic              high_stb,
    output logic              rise_viol
);

    scl_state_e        state_q, state_d;
    logic [LEN_W-1:0]  ph_cnt_q;
    logic [RISE_W-1:0] wait_cnt_q;
    logic              viol_q;
    logic              low_last, high_last, rise_low;

    assign low_last  = (ph_cnt_q == lo_len - LEN_W'(1));
    assign high_last = (ph_cnt_q == hi_len - LEN_W'(1));
    assign rise_low  = (state_q == ST_RISE) && !scl_in && !stretch_hold;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (run)       state_d = ST_LOW;
                ST_LOW:  if (low_last)  state_d = ST_RISE;
                ST_RISE: if (scl_in)    state_d = ST_HIGH;
                ST_HIGH: if (high_last) state_d = run ? ST_LOW : ST_IDLE;
                default:                state_d = ST_IDLE;
            endcase
        end
    end

    // phase counter, rise-wait counter and sticky fault
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt_q   <= '0;
            wait_cnt_q <= '0;
            viol_q     <= 1'b0;
        end else if (!en) begin
            ph_cnt_q   <= '0;
            wait_cnt_q <= '0;
            viol_q     <= 1'b0;
        end else begin
            if ((state_q == ST_LOW && !low_last) || (state_q == ST_HIGH && !high_last))
                ph_cnt_q <= ph_cnt_q + LEN_W'(1);
            else
                ph_cnt_q <= '0;

            if (state_q != ST_RISE)
                wait_cnt_q <= '0;
            else if (rise_low && wait_cnt_q < rise_lim)
                wait_cnt_q <= wait_cnt_q + RISE_W'(1);

            if (rise_low && wait_cnt_q >= rise_lim)
                viol_q <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        scl_pull  = (state_q == ST_LOW);
        low_stb   = (state_q == ST_LOW)  && (ph_cnt_q == '0);
        high_stb  = (state_q == ST_HIGH) && (ph_cnt_q == '0);
        rise_viol = viol_q;
    end

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull && !low_stb && !high_stb && !rise_viol)); // R7

    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> (ph_cnt_q < lo_len)); // R1

    AST_HIGH_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        high_stb |-> $past(scl_in)); // R9

    AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_pull) && $past(state_q == ST_IDLE)) |-> $past(en && run)); // R8

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(rise_viol)) |-> rise_viol); // R10

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_gen_pkg::*;
#(
    parameter int CCR_W  = DEF_CCR_W,
    parameter int RISE_W = DEF_RISE_W,
    localparam int CTRL_W = CCR_W + 2,
    localparam int LEN_W  = CCR_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [RISE_W-1:0] cfg_rise,
    input  logic              run,
    input  logic              scl_in,
    input  logic              stretch_hold,
    output logic              scl_pull,
    output logic              low_stb,
    output logic              high_stb,
    output logic              rise_viol
);

    logic              fast_q, duty_q;
    logic [CCR_W-1:0]  count_q;
    logic [RISE_W-1:0] rise_q;
    logic [LEN_W-1:0]  lo_len, hi_len;

    scl_cfg_regs #(.CCR_W(CCR_W), .RISE_W(RISE_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cfg_we   (cfg_we),
        .cfg_ctrl (cfg_ctrl),
        .cfg_rise (cfg_rise),
        .fast_q   (fast_q),
        .duty_q   (duty_q),
        .count_q  (count_q),
        .rise_q   (rise_q)
    );

    scl_phase_len #(.CCR_W(CCR_W), .LEN_W(LEN_W)) len_i (
        .fast   (fast_q),
        .duty   (duty_q),
        .count  (count_q),
        .lo_len (lo_len),
        .hi_len (hi_len)
    );

    scl_seq #(.LEN_W(LEN_W), .RISE_W(RISE_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .run          (run),
        .scl_in       (scl_in),
        .stretch_hold (stretch_hold),
        .lo_len       (lo_len),
        .hi_len       (hi_len),
        .rise_lim     (rise_q),
        .scl_pull     (scl_pull),
        .low_stb      (low_stb),
        .high_stb     (high_stb),
        .rise_viol    (rise_viol)
    );

endmodule

// File: tb/scl_rate_gen_tb_top.sv
`timescale 1ns/1ps
module scl_rate_gen_tb_top;

    localparam int CCR_W  = 12;
    localparam int RISE_W = 6;
    localparam int CTRL_W = CCR_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, cfg_we = 1'b0, run = 1'b0, stretch_hold = 1'b0;
    logic [CTRL_W-1:0] cfg_ctrl = '0;
    logic [RISE_W-1:0] cfg_rise = '0;
    logic slave_hold = 1'b0;
    logic scl_in, scl_pull, low_stb, high_stb, rise_viol;

    always #10 clk = ~clk;   // 50 MHz

    // wired-AND bus: master pull or a slave/slow edge holding it low
    assign scl_in = !scl_pull && !slave_hold;

    scl_rate_gen #(.CCR_W(CCR_W), .RISE_W(RISE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
        .cfg_rise(cfg_rise), .run(run), .scl_in(scl_in), .stretch_hold(stretch_hold),
        .scl_pull(scl_pull), .low_stb(low_stb), .high_stb(high_stb), .rise_viol(rise_viol)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R7";
    bit cmp_on = 1'b0;

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph = 0;       // 0 idle, 1 low, 2 waiting for line, 3 high
    int m_left = 0;
    int m_wcnt = 0;
    bit m_viol = 0;
    bit m_fast = 0, m_duty = 0;
    int m_n = 0, m_rise = 63;

    function automatic int m_unit();
        return (m_n == 0) ? 1 : m_n;
    endfunction
    function automatic int m_lo();
        if (!m_fast) return m_unit();
        if (m_duty) return 16 * m_unit();
        return 2 * m_unit();
    endfunction
    function automatic int m_hi();
        if (!m_fast) return m_unit();
        if (m_duty) return 9 * m_unit();
        return m_unit();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_wcnt = 0; m_viol = 0;
            m_fast = 0; m_duty = 0; m_n = 0; m_rise = 63;
        end else begin
            if (!en) begin
                m_ph = 0; m_wcnt = 0; m_viol = 0;
            end else begin
                case (m_ph)
                    0: if (run) begin m_ph = 1; m_left = m_lo(); end
                    1: begin
                        m_left--;
                        if (m_left == 0) begin m_ph = 2; m_wcnt = 0; end
                    end
                    2: begin
                        if (scl_in) begin m_ph = 3; m_left = m_hi(); end
                        else if (!stretch_hold) begin
                            if (m_wcnt >= m_rise) m_viol = 1;
                            else m_wcnt++;
                        end
                    end
                    default: begin
                        m_left--;
                        if (m_left == 0) begin
                            if (run) begin m_ph = 1; m_left = m_lo(); end
                            else m_ph = 0;
                        end
                    end
                endcase
            end
            if (cfg_we && !en) begin
                m_fast = cfg_ctrl[CTRL_W-1];
                m_duty = cfg_ctrl[CTRL_W-2];
                m_n    = int'(cfg_ctrl[CCR_W-1:0]);
                m_rise = int'(cfg_rise);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(int'(scl_pull),  int'(m_ph == 1), {cur_req, " model scl_pull"});
            chk(int'(low_stb),   int'(m_ph == 1 && m_left == m_lo()), {cur_req, " model low_stb"});
            chk(int'(high_stb),  int'(m_ph == 3 && m_left == m_hi()), {cur_req, " model high_stb"});
            chk(int'(rise_viol), int'(m_viol), {cur_req, " model rise_viol"});
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [CTRL_W-1:0] mk(input bit f, input bit d, input int n);
        return {f, d, CCR_W'(n)};
    endfunction

    task automatic restart(input bit f, input bit d, input int n, input int r);
        en = 1'b0; run = 1'b0;
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctrl = mk(f, d, n); cfg_rise = RISE_W'(r);
        @(negedge clk);
        cfg_we = 1'b0; en = 1'b1; run = 1'b1;
        @(negedge clk);
        chk(int'(scl_pull), 1, "R8 first low after start");
        chk(int'(low_stb),  1, "R8 low strobe at start");
    endtask

    task automatic measure(input int exp_lo, input int exp_hi, input string tag);
        int lo = 0;
        int hi = 0;
        while (!low_stb) @(negedge clk);
        while (scl_pull) begin lo++; @(negedge clk); end
        while (!high_stb) @(negedge clk);
        while (!scl_pull) begin hi++; @(negedge clk); end
        chk(lo, exp_lo, {tag, " low length"});
        chk(hi, exp_hi, {tag, " high length"});
    endtask

    // ---------------- main sequence ----------------
    initial begin
        @(negedge clk);
        chk(int'(scl_pull) + int'(low_stb) + int'(high_stb) + int'(rise_viol), 0, "R7 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        cur_req = "R1";
        restart(1'b0, 1'b0, 5, 40);
        measure(5, 5, "R1 standard N=5");
        measure(5, 5, "R1 standard N=5 second period");

        cur_req = "R7";
        en = 1'b0;
        @(negedge clk);
        chk(int'(scl_pull) + int'(low_stb) + int'(high_stb), 0, "R7 disabled releases");

        cur_req = "R2";
        restart(1'b1, 1'b0, 3, 40);
        measure(6, 3, "R2 fast 2:1 N=3");

        cur_req = "R3";
        restart(1'b1, 1'b1, 2, 40);
        measure(32, 18, "R3 fast 16:9 N=2");

        cur_req = "R4";
        restart(1'b0, 1'b1, 4, 40);
        measure(4, 4, "R4 duty ignored in standard");

        cur_req = "R5";
        restart(1'b0, 1'b0, 0, 40);
        measure(1, 1, "R5 zero count standard");
        restart(1'b1, 1'b1, 0, 40);
        measure(16, 9, "R5 zero count fast 16:9");
        restart(1'b1, 1'b0, 0, 40);
        measure(2, 1, "R5 zero count fast 2:1");

        cur_req = "R6";
        restart(1'b0, 1'b0, 5, 40);
        cfg_we = 1'b1; cfg_ctrl = mk(1'b1, 1'b1, 20); cfg_rise = RISE_W'(1);
        @(negedge clk);
        cfg_we = 1'b0;
        measure(5, 5, "R6 write while enabled ignored");
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        measure(5, 5, "R6 timing kept after re-enable");

        cur_req = "R9";
        restart(1'b0, 1'b0, 3, 10);
        slave_hold = 1'b1; stretch_hold = 1'b1;
        while (scl_pull) @(negedge clk);
        begin
            int seen = 0;
            for (int k = 0; k < 7; k++) begin
                if (high_stb) seen++;
                @(negedge clk);
            end
            chk(seen, 0, "R9 no high while held low");
        end
        slave_hold = 1'b0;
        @(negedge clk);
        chk(int'(high_stb), 1, "R9 high strobe one clock after line high");
        chk(int'(rise_viol), 0, "R10 intentional stretch not flagged");
        stretch_hold = 1'b0;

        cur_req = "R10";
        restart(1'b0, 1'b0, 3, 3);
        slave_hold = 1'b1;
        while (scl_pull) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(int'(rise_viol), 0, "R10 no flag within limit");
        @(negedge clk);
        chk(int'(rise_viol), 1, "R10 flag after limit exceeded");
        slave_hold = 1'b0;
        measure(3, 3, "R10 clocking resumes");
        chk(int'(rise_viol), 1, "R10 flag sticky while enabled");
        en = 1'b0;
        @(negedge clk);
        chk(int'(rise_viol), 0, "R10 flag cleared by disable");

        cur_req = "R11";
        restart(1'b0, 1'b0, 4, 40);
        while (!high_stb) @(negedge clk);
        run = 1'b0;
        begin
            int pulls = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (scl_pull || low_stb) pulls++;
            end
            chk(pulls, 0, "R11 idle after run drops");
        end
        run = 1'b1;
        @(negedge clk);
        chk(int'(low_stb), 1, "R8 restart from idle on run");

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule